// File: doc/BRIEF.md
# Scalar Point Multiplication Sequencer

This block is the control engine for computing Q = k·P on an elliptic curve. It does no field or point arithmetic itself. It holds the base point and one or two working points, walks the bits of a scalar k of `N_BITS` bits, and hands point-double and point-add commands to an external arithmetic unit one at a time. Each command is held until the arithmetic unit acknowledges it with a result, and the sequencer writes that result back into the working register the schedule names.

Two schedules are offered and chosen per operation by `mode`:

- **Mode 0 (double-and-add).** The accumulator is loaded with P at the highest set bit of k. The sequencer then moves downward one bit at a time. Each step doubles the accumulator, and adds P only when the bit is 1.
- **Mode 1 (ladder).** This is the regular two-register ladder. It starts from R0 = identity and R1 = P, visits every one of the `N_BITS` bits, and always issues one add followed by one double. At every step the difference R1 − R0 stays equal to P.

The states are:

| State | Role |
|---|---|
| IDLE | Waits for `start`. |
| SETUP | Loads the working registers and selects the first command. |
| DBL | Holds a double command. |
| ADD | Holds an add command. |
| NEXT | Moves to the next lower bit. |
| FINISH | Pulses `done`. |

The transitions are:

- IDLE→SETUP on `start`.
- SETUP→FINISH on k = 0, or on k = 1 in mode 0.
- SETUP→ADD in mode 1, and SETUP→DBL otherwise.
- DBL→ADD on acknowledge when the bit is 1 in mode 0.
- DBL→NEXT on acknowledge otherwise.
- ADD→DBL on acknowledge in mode 1.
- ADD→NEXT on acknowledge in mode 0.
- NEXT→FINISH at bit 0.
- NEXT→ADD or NEXT→DBL otherwise, by mode.
- FINISH→IDLE.

Top module: `smul_seq`

## Requirements
- R1: A `start` pulse while `busy` is low captures `scalar`, `mode`, `p_x` and `p_y`, and `busy` is high from the next cycle until the cycle after `done`. A `start` pulse while `busy` is high is ignored: the running operation finishes with the values captured at its own start.
- R2: A scalar of zero produces `done` with `q_inf` = 1. No command is issued, whatever the mode.
- R3: In mode 0, the number of double commands equals the index of the highest set bit of k, and the number of add commands equals the number of set bits minus one. A scalar of 1 therefore returns P with no command at all.
- R4: In mode 0, every step issues a double first and then, only when the current bit is 1, an add with operand B equal to P. Two add commands are never accepted back to back, and the first command is a double.
- R5: In mode 1, every nonzero scalar yields exactly `N_BITS` add and `N_BITS` double commands. They strictly alternate, starting with an add, whatever the bit values.
- R6: In mode 1, an add takes A = R0 and B = R1 and writes R1 when the bit is 0 or R0 when the bit is 1. A double takes R0 when the bit is 0 or R1 when the bit is 1, and writes the same register. The result Q is R0.
- R7: `cmd_req` is high in the DBL and ADD states. Once raised, it and all operand and opcode outputs (`cmd_op`: 0 = double, 1 = add; a double carries B = A) stay unchanged until the cycle in which `cmd_ack` is high.
- R8: `done` is high for exactly one cycle. `q_inf`, `q_x` and `q_y` then hold k·P and keep that value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| mode | input | 1 | 0 = double-and-add, 1 = ladder |
| scalar | input | N_BITS | Scalar k |
| p_x | input | COORD_W | Base point x coordinate |
| p_y | input | COORD_W | Base point y coordinate |
| cmd_req | output | 1 | Command valid |
| cmd_op | output | 1 | 0 = double, 1 = add |
| cmd_a_inf | output | 1 | Operand A is the identity |
| cmd_a_x | output | COORD_W | Operand A x |
| cmd_a_y | output | COORD_W | Operand A y |
| cmd_b_inf | output | 1 | Operand B is the identity |
| cmd_b_x | output | COORD_W | Operand B x |
| cmd_b_y | output | COORD_W | Operand B y |
| cmd_ack | input | 1 | Command complete, result valid |
| res_inf | input | 1 | Result is the identity |
| res_x | input | COORD_W | Result x |
| res_y | input | COORD_W | Result y |
| q_inf | output | 1 | Product is the identity |
| q_x | output | COORD_W | Product x |
| q_y | output | COORD_W | Product y |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is the ladder's early iterations, where R0 is still the identity and must be doubled and added through the external unit without corrupting the invariant. Leading-zero scalars such as 0x00A0 in mode 1 drive many such iterations. The bench's arithmetic model represents a point as a multiple of P, with coordinates scaled linearly and an explicit identity flag. Every final x and y can therefore be predicted as k times the base coordinates. Varying the acknowledge latency from zero to three cycles exercises both back-to-back commands and long holds of the same request.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_DBL,
        S_ADD,
        S_NEXT,
        S_FINISH
    } seq_state_e;

    localparam logic OP_DBL   = 1'b0;
    localparam logic OP_ADD   = 1'b1;
    localparam logic MODE_DA  = 1'b0;
    localparam logic MODE_LAD = 1'b1;

endpackage

// File: rtl/smul_msb_find.sv
module smul_msb_find #(
    parameter int N_BITS = 16,
    localparam int IDX_W = $clog2(N_BITS)
) (
    input  logic [N_BITS-1:0] value,
    output logic [IDX_W-1:0]  top_idx
);

    // Highest set bit wins; zero input yields index 0.
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < N_BITS; i++) begin
            if (value[i]) top_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/smul_opnd_sel.sv
module smul_opnd_sel
    import smul_pkg::*;
#(
    parameter int PW = 33
) (
    input  logic          mode,
    input  logic          op,
    input  logic          bit_val,
    input  logic [PW-1:0] r0,
    input  logic [PW-1:0] r1,
    input  logic [PW-1:0] pbase,
    output logic [PW-1:0] opnd_a,
    output logic [PW-1:0] opnd_b,
    output logic          wr_r0,
    output logic          wr_r1
);

    always_comb begin
        if (mode == MODE_DA) begin
            opnd_a = r0;
            opnd_b = (op == OP_ADD) ? pbase : r0;
            wr_r0  = 1'b1;
            wr_r1  = 1'b0;
        end else if (op == OP_ADD) begin
            opnd_a = r0;
            opnd_b = r1;
            wr_r0  = bit_val;
            wr_r1  = !bit_val;
        end else begin
            opnd_a = bit_val ? r1 : r0;
            opnd_b = bit_val ? r1 : r0;
            wr_r0  = !bit_val;
            wr_r1  = bit_val;
        end
    end

endmodule

// File: rtl/smul_seq.sv
module smul_seq
    import smul_pkg::*;
#(
    parameter int N_BITS  = 16,
    parameter int COORD_W = 16,
    localparam int IDX_W  = $clog2(N_BITS),
    localparam int PW     = 2 * COORD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode,
    input  logic [N_BITS-1:0]  scalar,
    input  logic [COORD_W-1:0] p_x,
    input  logic [COORD_W-1:0] p_y,
    output logic               cmd_req,
    output logic               cmd_op,
    output logic               cmd_a_inf,
    output logic [COORD_W-1:0] cmd_a_x,
    output logic [COORD_W-1:0] cmd_a_y,
    output logic               cmd_b_inf,
    output logic [COORD_W-1:0] cmd_b_x,
    output logic [COORD_W-1:0] cmd_b_y,
    input  logic               cmd_ack,
    input  logic               res_inf,
    input  logic [COORD_W-1:0] res_x,
    input  logic [COORD_W-1:0] res_y,
    output logic               q_inf,
    output logic [COORD_W-1:0] q_x,
    output logic [COORD_W-1:0] q_y,
    output logic               busy,
    output logic               done
);

    localparam logic [PW-1:0] PT_INF = {1'b1, {(PW-1){1'b0}}};

    seq_state_e          state, state_nx;
    logic                mode_q;
    logic [N_BITS-1:0]   k_q;
    logic [IDX_W-1:0]    idx;
    logic [IDX_W-1:0]    top_idx;
    logic [PW-1:0]       r0, r1, pbase;
    logic [PW-1:0]       opnd_a, opnd_b;
    logic                wr_r0, wr_r1;
    logic                cur_bit;
    logic                k_zero;
    logic                op_cur;

    assign cur_bit = k_q[idx];
    assign k_zero  = (k_q == '0);

    smul_msb_find #(.N_BITS(N_BITS)) u_msb (
        .value   (k_q),
        .top_idx (top_idx)
    );

    smul_opnd_sel #(.PW(PW)) u_sel (
        .mode    (mode_q),
        .op      (op_cur),
        .bit_val (cur_bit),
        .r0      (r0),
        .r1      (r1),
        .pbase   (pbase),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .wr_r0   (wr_r0),
        .wr_r1   (wr_r1)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_SETUP;
            S_SETUP: begin
                if (k_zero)                                  state_nx = S_FINISH;
                else if (mode_q == MODE_LAD)                 state_nx = S_ADD;
                else if (top_idx == '0)                      state_nx = S_FINISH;
                else                                         state_nx = S_DBL;
            end
            S_DBL: begin
                if (cmd_ack) begin
                    if (mode_q == MODE_DA && cur_bit)        state_nx = S_ADD;
                    else                                     state_nx = S_NEXT;
                end
            end
            S_ADD: begin
                if (cmd_ack) begin
                    if (mode_q == MODE_LAD)                  state_nx = S_DBL;
                    else                                     state_nx = S_NEXT;
                end
            end
            S_NEXT: begin
                if (idx == '0)                               state_nx = S_FINISH;
                else if (mode_q == MODE_LAD)                 state_nx = S_ADD;
                else                                         state_nx = S_DBL;
            end
            S_FINISH:                                        state_nx = S_IDLE;
            default:                                         state_nx = S_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        cmd_req = (state == S_DBL) || (state == S_ADD);
        op_cur  = (state == S_ADD) ? OP_ADD : OP_DBL;
        done    = (state == S_FINISH);
        busy    = (state != S_IDLE);
    end

    assign cmd_op    = op_cur;
    assign cmd_a_inf = opnd_a[PW-1];
    assign cmd_a_x   = opnd_a[PW-2 -: COORD_W];
    assign cmd_a_y   = opnd_a[COORD_W-1:0];
    assign cmd_b_inf = opnd_b[PW-1];
    assign cmd_b_x   = opnd_b[PW-2 -: COORD_W];
    assign cmd_b_y   = opnd_b[COORD_W-1:0];

    assign q_inf = r0[PW-1];
    assign q_x   = r0[PW-2 -: COORD_W];
    assign q_y   = r0[COORD_W-1:0];

    // Working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_DA;
            k_q    <= '0;
            idx    <= '0;
            r0     <= PT_INF;
            r1     <= PT_INF;
            pbase  <= PT_INF;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        mode_q <= mode;
                        k_q    <= scalar;
                        pbase  <= {1'b0, p_x, p_y};
                    end
                end
                S_SETUP: begin
                    r1 <= pbase;
                    if (k_zero || mode_q == MODE_LAD) r0 <= PT_INF;
                    else                             r0 <= pbase;
                    if (mode_q == MODE_LAD)          idx <= IDX_W'(N_BITS - 1);
                    else if (top_idx != '0)          idx <= top_idx - IDX_W'(1);
                end
                S_DBL, S_ADD: begin
                    if (cmd_ack) begin
                        if (wr_r0) r0 <= {res_inf, res_x, res_y};
                        if (wr_r1) r1 <= {res_inf, res_x, res_y};
                    end
                end
                S_NEXT: begin
                    if (idx != '0) idx <= idx - IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/smul_seq_chk.sv
module smul_seq_chk #(
    parameter int N_BITS  = 16,
    parameter int COORD_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               mode,
    input logic [N_BITS-1:0]  scalar,
    input logic               busy,
    input logic               done,
    input logic               cmd_req,
    input logic               cmd_op,
    input logic               cmd_ack,
    input logic               cmd_a_inf,
    input logic [COORD_W-1:0] cmd_a_x,
    input logic [COORD_W-1:0] cmd_a_y,
    input logic               cmd_b_inf,
    input logic [COORD_W-1:0] cmd_b_x,
    input logic [COORD_W-1:0] cmd_b_y,
    input logic               q_inf
);

    logic zero_run, mode_l, last_valid, last_add;
    logic accepted;

    assign accepted = cmd_req && cmd_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_run   <= 1'b0;
            mode_l     <= 1'b0;
            last_valid <= 1'b0;
            last_add   <= 1'b0;
        end else if (start && !busy) begin
            zero_run   <= (scalar == '0);
            mode_l     <= mode;
            last_valid <= 1'b0;
            last_add   <= 1'b0;
        end else if (accepted) begin
            last_valid <= 1'b1;
            last_add   <= cmd_op;
        end
    end

    // R1
    busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2
    zero_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && zero_run) |-> !cmd_req);

    // R2
    zero_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero_run) |-> q_inf);

    // R4
    da_no_double_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && !mode_l && cmd_op) |-> (last_valid && !last_add));

    // R5
    lad_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && mode_l) |-> (last_valid ? (cmd_op != last_add) : cmd_op));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> cmd_req);

    // R7
    opnd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> ($stable(cmd_op) && $stable(cmd_a_inf) && $stable(cmd_a_x)
            && $stable(cmd_a_y) && $stable(cmd_b_inf) && $stable(cmd_b_x) && $stable(cmd_b_y)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind smul_seq smul_seq_chk #(.N_BITS(N_BITS), .COORD_W(COORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .scalar    (scalar),
    .busy      (busy),
    .done      (done),
    .cmd_req   (cmd_req),
    .cmd_op    (cmd_op),
    .cmd_ack   (cmd_ack),
    .cmd_a_inf (cmd_a_inf),
    .cmd_a_x   (cmd_a_x),
    .cmd_a_y   (cmd_a_y),
    .cmd_b_inf (cmd_b_inf),
    .cmd_b_x   (cmd_b_x),
    .cmd_b_y   (cmd_b_y),
    .q_inf     (q_inf)
);

// File: tb/smul_seq_tb.sv
`timescale 1ns/1ps
module smul_seq_tb;

    localparam int N  = 16;
    localparam int W  = 16;
    localparam int NV = 8;

    // {mode, latency[3:0], scalar[15:0]}
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 4'd0, 16'h0001},
        {1'b0, 4'd1, 16'hB5C3},
        {1'b0, 4'd2, 16'h8000},
        {1'b0, 4'd0, 16'hFFFF},
        {1'b1, 4'd1, 16'h0001},
        {1'b1, 4'd0, 16'hB5C3},
        {1'b1, 4'd3, 16'hFFFF},
        {1'b1, 4'd0, 16'h00A0}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
    logic [N-1:0] scalar = '0;
    logic [W-1:0] p_x = '0, p_y = '0;
    logic cmd_req, cmd_op, cmd_a_inf, cmd_b_inf;
    logic [W-1:0] cmd_a_x, cmd_a_y, cmd_b_x, cmd_b_y;
    logic cmd_ack = 1'b0, res_inf = 1'b0;
    logic [W-1:0] res_x = '0, res_y = '0;
    logic q_inf, busy, done;
    logic [W-1:0] q_x, q_y;

    int total = 0, bad = 0, cyc = 0;
    int n_dbl = 0, n_add = 0, r7_bad = 0, lat = 0, lat_cnt = 0;
    logic [2*W+2:0] snap;

    always #2 clk = ~clk;

    smul_seq #(.N_BITS(N), .COORD_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .scalar(scalar),
        .p_x(p_x), .p_y(p_y), .cmd_req(cmd_req), .cmd_op(cmd_op),
        .cmd_a_inf(cmd_a_inf), .cmd_a_x(cmd_a_x), .cmd_a_y(cmd_a_y),
        .cmd_b_inf(cmd_b_inf), .cmd_b_x(cmd_b_x), .cmd_b_y(cmd_b_y),
        .cmd_ack(cmd_ack), .res_inf(res_inf), .res_x(res_x), .res_y(res_y),
        .q_inf(q_inf), .q_x(q_x), .q_y(q_y), .busy(busy), .done(done)
    );

    // Arithmetic-unit model: a point is m*P, coordinates scale linearly.
    always @(negedge clk) begin
        if (cmd_ack) begin
            cmd_ack = 1'b0;
            lat_cnt = 0;
        end else if (cmd_req) begin
            if (lat_cnt == 0) snap = {cmd_op, cmd_a_inf, cmd_a_x, cmd_a_y};
            else if (snap != {cmd_op, cmd_a_inf, cmd_a_x, cmd_a_y}) r7_bad++;
            if (lat_cnt >= lat) begin
                if (cmd_op == 1'b0) begin
                    n_dbl++;
                    res_inf = cmd_a_inf;
                    res_x   = cmd_a_x << 1;
                    res_y   = cmd_a_y << 1;
                end else begin
                    n_add++;
                    if (cmd_a_inf) begin
                        res_inf = cmd_b_inf; res_x = cmd_b_x; res_y = cmd_b_y;
                    end else if (cmd_b_inf) begin
                        res_inf = 1'b0; res_x = cmd_a_x; res_y = cmd_a_y;
                    end else begin
                        res_inf = 1'b0; res_x = cmd_a_x + cmd_b_x; res_y = cmd_a_y + cmd_b_y;
                    end
                end
                cmd_ack = 1'b1;
            end else begin
                lat_cnt++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int msb_of(input logic [N-1:0] v);
        int m = 0;
        for (int i = 0; i < N; i++) if (v[i]) m = i;
        return m;
    endfunction

    task automatic run(input logic md, input logic [N-1:0] k, input int l,
                       input logic [W-1:0] bx, input logic [W-1:0] by, input logic inject);
        int waited;
        logic [W-1:0] ex, ey;
        lat = l; n_dbl = 0; n_add = 0; r7_bad = 0;
        @(negedge clk);
        mode = md; scalar = k; p_x = bx; p_y = by; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", busy, 1);
        if (inject) begin
            @(negedge clk); @(negedge clk);
            scalar = 16'h0003; mode = ~md; p_x = 16'h0001; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk); waited++;
        end
        chk(done == 1'b1, "R8 done seen", done, 1);
        ex = W'(k * bx); ey = W'(k * by);
        if (k == '0) begin
            chk(q_inf == 1'b1, "R2 zero gives identity", q_inf, 1);
            chk(n_dbl + n_add == 0, "R2 no commands", n_dbl + n_add, 0);
        end else begin
            chk(q_inf == 1'b0 && q_x == ex, "R6 result x", q_x, ex);
            chk(q_y == ey, "R6 result y", q_y, ey);
            if (md == 1'b0) begin
                chk(n_dbl == msb_of(k), "R3 double count", n_dbl, msb_of(k));
                chk(n_add == $countones(k) - 1, "R4 add count", n_add, $countones(k) - 1);
            end else begin
                chk(n_dbl == N && n_add == N, "R5 ladder command count", n_dbl + n_add, 2 * N);
            end
        end
        chk(r7_bad == 0, "R7 operands held", r7_bad, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        @(negedge clk); @(negedge clk);
        chk(q_x == ((k == '0) ? q_x : ex) && busy == 1'b0, "R8 result held", q_x, ex);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && cmd_req == 1'b0, "R1 reset state",
            {busy, done, cmd_req}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            run(VEC[i][20], VEC[i][15:0], int'(VEC[i][19:16]),
                W'(16'h1357 + i), W'(16'h0F0F + 3 * i), 1'b0);
        end
        // R2 zero scalar in both modes
        run(1'b0, 16'h0000, 0, 16'h1111, 16'h2222, 1'b0);
        run(1'b1, 16'h0000, 1, 16'h1111, 16'h2222, 1'b0);
        // R1 start while busy is ignored (both modes)
        run(1'b0, 16'h9A5D, 2, 16'h0ACE, 16'h0321, 1'b1);
        run(1'b1, 16'h4C21, 1, 16'h0BEE, 16'h0777, 1'b1);
        // R3 scalar of one needs no command
        run(1'b0, 16'h0001, 0, 16'h7777, 16'h0101, 1'b0);
        chk(n_dbl + n_add == 0, "R3 k=1 no commands", n_dbl + n_add, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule